// File: doc/BRIEF.md
# Frequency Bin Dump Controller

This block sequences the read-out of finished transform results from a result memory. After the transform engine signals completion, the controller waits for the first dump strobe. On that strobe it raises the data-available flag and issues the first read address of the selected bin range. Each further strobe moves the address one bin forward. The strobe that follows the last bin in the range hands that bin onward and closes the dump.

Software-visible control bits choose the portion of the spectrum to deliver: all bins, the lower quarter, the lower half or the upper half. A hold option keeps the data-available flag asserted after the dump ends, so the results can be read again, until the input-load enable falls to mark the next data block. A delay option shifts the data-available flag by a fixed pipeline latency to match a downstream stage. In that mode the output drive enables still follow the real dump activity. The drive enables stand in for tri-state control of the data and scale-tag buses.

Top module: `fft_bin_dump`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `dav`, `rdValid`, `dataDrive` and `tagDrive` are 0 and `rdAddr` is 0.
- R2: After an `xformDone` pulse, the first `dumpStrobe` starts the dump. On the cycle after the edge that samples that strobe, the dump is active (`dav`=1 when not delayed), `rdAddr` holds the first bin of the range and `rdValid` is 1 for one cycle.
- R3: While a dump is active, each `dumpStrobe` that is not on the last bin of the range raises `rdAddr` by one and pulses `rdValid` on the next cycle.
- R4: The range is taken from `dumpRange` when `xformDone` is accepted. For N points, the encodings are: 00 gives bins 0..N-1; 01 gives bins 0..N/4-1; 10 gives bins 0..N/2-1; 11 gives bins N/2..N-1.
- R5: With hold off, the `dumpStrobe` sampled while `rdAddr` is on the last bin of the range ends the dump on the next cycle. That strobe issues no read.
- R6: With `holdDavCfg`=1, the strobe on the last bin keeps the dump active. Later strobes wrap the address from the last bin back to the first bin of the range. The dump ends the cycle after a falling edge of `loadEnN` is sampled.
- R7: With `delayDavCfg`=1, `dav` equals the dump-active state delayed by `DAV_DELAY` clocks. `dataDrive` and `tagDrive` do not wait for the delayed `dav`.
- R8: `dataDrive` and `tagDrive` are 1 exactly when a dump is active and `outEnN` is 0. They follow `outEnN` in the same cycle, including mid-dump.
- R9: A `dumpStrobe` while no dump is pending or active changes no output.
- R10: An `xformDone` pulse during an active, unheld dump is ignored. While a held dump is active, an `xformDone` pulse ends it and arms a new dump.
- R11: `rdValid` is never 1 with `rdAddr` outside the selected range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| xformDone | input | 1 | One-cycle pulse: transform results are ready |
| dumpStrobe | input | 1 | One-cycle output strobe, synchronous to clk |
| outEnN | input | 1 | Active-low output enable |
| loadEnN | input | 1 | Active-low input-load enable; its falling edge marks a new block |
| holdDavCfg | input | 1 | Keep the dump active after the last bin until the next load edge |
| delayDavCfg | input | 1 | Delay `dav` by DAV_DELAY clocks |
| dumpRange | input | 2 | Range select: 00 all, 01 lower quarter, 10 lower half, 11 upper half |
| dav | output | 1 | Data-available flag |
| rdAddr | output | $clog2(N_POINTS) | Result memory read address |
| rdValid | output | 1 | A read of `rdAddr` is issued this cycle |
| dataDrive | output | 1 | Drive enable for the data bus |
| tagDrive | output | 1 | Drive enable for the scale-tag outputs |

## Verification
The registered results `rdAddr`, `rdValid` and the undelayed `dav` change one clock after the edge that samples a strobe, a done pulse or a load edge. The delayed `dav` follows `DAV_DELAY` clocks after the dump-active state changes. The drive enables respond to `outEnN` in the same cycle, with no register on the way. The bench drives inputs on falling edges and updates its behavioural model on each rising edge. It compares every output 1 ns after that rising edge, so every registered result is observed in its first cycle and every combinational one with the inputs that produced it.

// File: rtl/fft_dump_pkg.sv
package fft_dump_pkg;

  localparam logic [1:0] RANGE_ALL      = 2'b00;
  localparam logic [1:0] RANGE_LOW_QTR  = 2'b01;
  localparam logic [1:0] RANGE_LOW_HALF = 2'b10;
  localparam logic [1:0] RANGE_UP_HALF  = 2'b11;

  // Strobes from the sequencer to the address path
  typedef struct packed {
    logic capture;   // latch the range selection
    logic loadBase;  // address <= first bin of range, issue read
    logic step;      // address <= address + 1, issue read
  } dumpCmd_t;

  function automatic int rangeFirst(input logic [1:0] sel, input int pts);
    return (sel == RANGE_UP_HALF) ? pts / 2 : 0;
  endfunction

  function automatic int rangeLen(input logic [1:0] sel, input int pts);
    case (sel)
      RANGE_ALL:      return pts;
      RANGE_LOW_QTR:  return pts / 4;
      RANGE_LOW_HALF: return pts / 2;
      default:        return pts / 2;
    endcase
  endfunction

endpackage

// File: rtl/dump_seq_ctrl.sv
module dump_seq_ctrl
  import fft_dump_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     xformDone,
  input  logic     dumpStrobe,
  input  logic     loadEnN,
  input  logic     holdCfg,
  input  logic     atLast,
  output dumpCmd_t cmd,
  output logic     dumpActive
);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_DUMP, S_HOLD} seqState_e;

  seqState_e state, nextState;
  logic      loadEnQ;
  logic      loadFall;

  assign loadFall   = loadEnQ & ~loadEnN;
  assign dumpActive = (state == S_DUMP) || (state == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      loadEnQ <= 1'b1;
    end else begin
      state   <= nextState;
      loadEnQ <= loadEnN;
    end
  end

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (xformDone) begin
          cmd.capture = 1'b1;
          nextState   = S_PEND;
        end
      end
      S_PEND: begin
        if (dumpStrobe) begin
          cmd.loadBase = 1'b1;
          nextState    = S_DUMP;
        end
      end
      S_DUMP: begin
        if (dumpStrobe) begin
          if (atLast) nextState = holdCfg ? S_HOLD : S_IDLE;
          else        cmd.step  = 1'b1;
        end
      end
      S_HOLD: begin
        if (loadFall) begin
          nextState = S_IDLE;
        end else if (xformDone) begin
          cmd.capture = 1'b1;
          nextState   = S_PEND;
        end else if (dumpStrobe) begin
          if (atLast) cmd.loadBase = 1'b1;
          else        cmd.step     = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R5: last-bin strobe without hold closes the dump
  p_dump_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DUMP && dumpStrobe && atLast && !holdCfg) |=> !dumpActive);

  // R6: a held dump survives until a load edge or a new transform
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && loadEnQ == loadEnN && !xformDone) |=> dumpActive);

  // R9: a strobe in idle starts nothing
  p_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !xformDone) |=> !dumpActive);

endmodule

// File: rtl/dump_addr_path.sv
module dump_addr_path
  import fft_dump_pkg::*;
#(
  parameter int N_POINTS  = 256,
  parameter int DAV_DELAY = 8,
  localparam int ADDR_W   = $clog2(N_POINTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dumpCmd_t          cmd,
  input  logic              dumpActive,
  input  logic [1:0]        rangeSel,
  input  logic              outEnN,
  input  logic              delayCfg,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic              atLast,
  output logic              davOut,
  output logic              dataDrive,
  output logic              tagDrive
);

  initial begin
    assert (N_POINTS == 16 || N_POINTS == 64 || N_POINTS == 256 || N_POINTS == 1024)
      else $error("N_POINTS must be 16, 64, 256 or 1024");
    assert (DAV_DELAY >= 1) else $error("DAV_DELAY must be at least 1");
  end

  logic [1:0]        rangeLat;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] lastAddr;
  logic              davDelayed;

  assign baseAddr = ADDR_W'(rangeFirst(rangeLat, N_POINTS));
  assign lastAddr = ADDR_W'(rangeFirst(rangeLat, N_POINTS) + rangeLen(rangeLat, N_POINTS) - 1);
  assign atLast   = (rdAddr == lastAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeLat <= RANGE_ALL;
      rdAddr   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (cmd.capture) rangeLat <= rangeSel;
      if (cmd.loadBase)  rdAddr <= baseAddr;
      else if (cmd.step) rdAddr <= rdAddr + 1'b1;
      rdValid <= cmd.loadBase | cmd.step;
    end
  end

  // Pipeline that matches the downstream stage latency
  logic [DAV_DELAY-1:0] davPipe;
  generate
    if (DAV_DELAY == 1) begin : g_pipe_one
      always_ff @(posedge clk) begin
        if (!rstN) davPipe <= '0;
        else       davPipe <= dumpActive;
      end
    end else begin : g_pipe_many
      always_ff @(posedge clk) begin
        if (!rstN) davPipe <= '0;
        else       davPipe <= {davPipe[DAV_DELAY-2:0], dumpActive};
      end
    end
  endgenerate
  assign davDelayed = davPipe[DAV_DELAY-1];

  assign davOut    = delayCfg ? davDelayed : dumpActive;
  assign dataDrive = dumpActive & ~outEnN;
  assign tagDrive  = dataDrive;

  // R3: a step moves the address forward by exactly one bin
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step |=> (rdAddr == ADDR_W'($past(rdAddr) + 1'b1)) && rdValid);

  // R11: issued reads stay inside the latched range
  p_read_in_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdAddr >= baseAddr) && (rdAddr <= lastAddr));

  // R2: a read is only issued while the dump is active
  p_read_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> dumpActive);

  // R8: undelayed mode never drives without the flag
  p_drive_needs_dav_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!delayCfg && dataDrive) |-> davOut);

endmodule

// File: rtl/fft_bin_dump.sv
module fft_bin_dump
  import fft_dump_pkg::*;
#(
  parameter int N_POINTS  = 256,
  parameter int DAV_DELAY = 8,
  localparam int ADDR_W   = $clog2(N_POINTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xformDone,
  input  logic              dumpStrobe,
  input  logic              outEnN,
  input  logic              loadEnN,
  input  logic              holdDavCfg,
  input  logic              delayDavCfg,
  input  logic [1:0]        dumpRange,
  output logic              dav,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic              dataDrive,
  output logic              tagDrive
);

  dumpCmd_t cmd;
  logic     dumpActive;
  logic     atLast;

  dump_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .xformDone  (xformDone),
    .dumpStrobe (dumpStrobe),
    .loadEnN    (loadEnN),
    .holdCfg    (holdDavCfg),
    .atLast     (atLast),
    .cmd        (cmd),
    .dumpActive (dumpActive)
  );

  dump_addr_path #(
    .N_POINTS  (N_POINTS),
    .DAV_DELAY (DAV_DELAY)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .dumpActive (dumpActive),
    .rangeSel   (dumpRange),
    .outEnN     (outEnN),
    .delayCfg   (delayDavCfg),
    .rdAddr     (rdAddr),
    .rdValid    (rdValid),
    .atLast     (atLast),
    .davOut     (dav),
    .dataDrive  (dataDrive),
    .tagDrive   (tagDrive)
  );

endmodule

// File: tb/fft_bin_dump_tb_top.sv
`timescale 1ns/1ps
module fft_bin_dump_tb_top;

  localparam int N   = 256;
  localparam int DLY = 8;
  localparam int AW  = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xformDone = 1'b0, dumpStrobe = 1'b0, outEnN = 1'b0, loadEnN = 1'b1;
  logic holdDavCfg = 1'b0, delayDavCfg = 1'b0;
  logic [1:0] dumpRange = 2'b00;
  logic dav, rdValid, dataDrive, tagDrive;
  logic [AW-1:0] rdAddr;

  always #2.5 clk = ~clk;

  fft_bin_dump #(.N_POINTS(N), .DAV_DELAY(DLY)) dut_i (
    .clk(clk), .rstN(rstN), .xformDone(xformDone), .dumpStrobe(dumpStrobe),
    .outEnN(outEnN), .loadEnN(loadEnN), .holdDavCfg(holdDavCfg),
    .delayDavCfg(delayDavCfg), .dumpRange(dumpRange), .dav(dav),
    .rdAddr(rdAddr), .rdValid(rdValid), .dataDrive(dataDrive), .tagDrive(tagDrive)
  );

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  function automatic int firstBin(int r); return (r == 3) ? N / 2 : 0; endfunction
  function automatic int binCount(int r);
    return (r == 0) ? N : (r == 1) ? N / 4 : N / 2;
  endfunction

  // Behavioural model: 0 idle, 1 armed, 2 dumping, 3 held
  int  mSt = 0, mIdx = 0, mRng = 0, mAddr = 0;
  bit  mValid = 0, mAct = 0, mDav = 0, prevLoad = 1;
  bit  dq[$];

  always @(posedge clk) begin
    bit fall;
    cycles++;
    if (!rstN) begin
      mSt = 0; mIdx = 0; mRng = 0; mAddr = 0; mValid = 0; mAct = 0; mDav = 0;
      prevLoad = 1; dq.delete();
      repeat (DLY) dq.push_back(1'b0);
    end else begin
      fall = prevLoad && !loadEnN;
      prevLoad = loadEnN;
      mValid = 0;
      case (mSt)
        0: if (xformDone) begin mSt = 1; mRng = int'(dumpRange); end
        1: if (dumpStrobe) begin mSt = 2; mIdx = 0; mValid = 1; end
        2: if (dumpStrobe) begin
             if (mIdx == binCount(mRng) - 1) mSt = holdDavCfg ? 3 : 0;
             else begin mIdx++; mValid = 1; end
           end
        default: if (fall) mSt = 0;
           else if (xformDone) begin mSt = 1; mRng = int'(dumpRange); end
           else if (dumpStrobe) begin
             mIdx = (mIdx + 1) % binCount(mRng); mValid = 1;
           end
      endcase
      if (mValid) mAddr = firstBin(mRng) + mIdx;
      mAct = (mSt == 2) || (mSt == 3);
      dq.push_back(mAct);
      mDav = dq.pop_front();
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      cmp("dav", int'(dav), int'(delayDavCfg ? mDav : mAct));
      cmp("rdAddr", int'(rdAddr), mAddr);
      cmp("rdValid", int'(rdValid), int'(mValid));
      cmp("dataDrive", int'(dataDrive), int'(mAct && !outEnN));
      cmp("tagDrive", int'(tagDrive), int'(mAct && !outEnN));
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic pulseDone(); @(negedge clk) xformDone = 1; @(negedge clk) xformDone = 0; endtask
  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dumpStrobe = 1;
      @(negedge clk) dumpStrobe = 0;
      idle(i % 3);
    end
  endtask
  task automatic loadEdge(); @(negedge clk) loadEnN = 0; @(negedge clk) loadEnN = 1; endtask
  task automatic fullDump(int r);
    dumpRange = 2'(r); pulseDone(); strobe(binCount(r) + 1); idle(3);
  endtask

  initial begin
    idle(4);                          // R1: outputs held at reset values
    @(negedge clk) rstN = 1;
    idle(2);
    curReq = "R9"; strobe(4);         // strobes with nothing pending
    curReq = "R2"; fullDump(0);       // R3 R5 R11 also exercised
    curReq = "R4"; fullDump(1); fullDump(2); fullDump(3);
    curReq = "R8";                    // enable toggled mid-dump
    outEnN = 1; dumpRange = 2'b01; pulseDone(); strobe(10);
    @(negedge clk) outEnN = 0; strobe(20);
    @(negedge clk) outEnN = 1; strobe(35); @(negedge clk) outEnN = 0; idle(3);
    curReq = "R10";                   // done pulse during active dump
    dumpRange = 2'b10; pulseDone(); strobe(30); pulseDone(); strobe(N / 2 - 29); idle(3);
    curReq = "R6"; holdDavCfg = 1;    // held dump, wrap, then load edge
    fullDump(3); strobe(N / 2 + 5); idle(2); loadEdge(); idle(4);
    dumpRange = 2'b01; pulseDone(); strobe(N / 4 + 3);
    curReq = "R10"; pulseDone(); strobe(2); idle(2); loadEdge(); idle(3);
    holdDavCfg = 0;
    curReq = "R7"; delayDavCfg = 1;   // delayed flag, drive not delayed
    fullDump(1); idle(DLY + 4);
    outEnN = 1; dumpRange = 2'b11; pulseDone(); strobe(5);
    @(negedge clk) outEnN = 0; strobe(N / 2 - 4); idle(DLY + 4);
    curReq = "R11"; delayDavCfg = 0; fullDump(2);
    curReq = "R1"; @(negedge clk) rstN = 0; idle(3); @(negedge clk) rstN = 1; idle(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule